// File: doc/BRIEF.md
# Macroblock Reference Fetch Planner

This block turns the motion description of one inter-coded macroblock into a short list of rectangular read requests against the reference frame. Software or an upstream parser gives it the macroblock position, a partition shape code and up to sixteen quarter-sample motion vectors, then pulses a start strobe. The block walks the partitions and emits one rectangle per partition on a valid/ready stream. Each rectangle is an x, y, width and height in integer pixels. Each rectangle covers every integer sample that the six-tap interpolation of that partition will touch.

A partition is fetched as a single window because all of its 4×4 blocks share one vector. The margin is added only on an axis whose vector component has a fractional part: 2 pixels before and 3 pixels after. Vectors on a full-sample position therefore fetch exactly the partition footprint. After the last rectangle of a macroblock is accepted, the block pulses a done flag together with the total pixel count of the whole list, so that memory bandwidth can be budgeted. A new macroblock may be started in the same cycle as the final handshake of the previous one.

Top module: `ref_fetch_planner`

## Requirements
- R1: After a synchronous active-low reset, `req_valid`, `req_last` and `mb_done` are 0 and `mb_pixels` is 0.
- R2: A `mb_start` seen while idle is captured, and the first request is valid in the next cycle. The number of requests per macroblock is 1, 2, 2, 4, 8, 8 and 16 for shape codes 0 to 6. `req_last` is high only on the final request.
- R3: Shape codes are 0=16×16, 1=16×8, 2=8×16, 3=8×8, 4=8×4, 5=4×8 and 6=4×4. Partitions go top then bottom, or left then right, for the two-partition shapes. Quadrants go in z order (top-left, top-right, bottom-left, bottom-right). Inside a quadrant, sub-blocks go first along x and then along y. For example, a 4×8 partition with both components fractional yields a 9×13 window.
- R4: Horizontally, `req_x` = 16·`mb_col` + partition x offset + (mv_x >> 2, arithmetic). When mv_x[1:0] ≠ 0, 2 is subtracted from `req_x` and 5 is added to the partition width; otherwise `req_w` equals the partition width.
- R5: The vertical axis follows the same rule using mv_y, `mb_row`, the partition height, `req_y` and `req_h`, independently of the horizontal axis.
- R6: Partition p uses motion vector slot p of `mv_bus`. Slot k holds mv_x at bits [k·2·MV_W +: MV_W] and mv_y at bits [k·2·MV_W + MV_W +: MV_W], both two's complement in quarter samples.
- R7: While `req_valid` is high and `req_ready` is low, the request fields hold their values.
- R8: In the cycle after the final request is accepted, `mb_done` is high for that cycle and `mb_pixels` equals the sum of w·h over the macroblock's requests. `mb_pixels` holds that value until the next done.
- R9: `mb_start` while busy is ignored, except in the cycle where the final request is accepted. In that cycle the new macroblock is captured, and its first request is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_start | input | 1 | Start strobe for a macroblock |
| mb_col | input | MB_IDX_W | Macroblock column |
| mb_row | input | MB_IDX_W | Macroblock row |
| part_mode | input | 3 | Partition shape code |
| mv_bus | input | 16·2·MV_W | Sixteen packed motion vectors |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by consumer |
| req_x | output | COORD_W | Window left column, signed |
| req_y | output | COORD_W | Window top row, signed |
| req_w | output | 5 | Window width |
| req_h | output | 5 | Window height |
| req_last | output | 1 | Final request of the macroblock |
| mb_done | output | 1 | One-cycle pulse after the final handshake |
| mb_pixels | output | PIX_W | Total pixels requested for the macroblock |

## Verification
The final handshake of one macroblock and the capture of the next can fall in the same cycle. In that cycle the done pulse and pixel total of the old macroblock must appear alongside the first request of the new one. The bench provokes this by holding ready high on a final request while pulsing start with fresh inputs. In the following cycle it checks the old total and the new macroblock's first rectangle. Starts issued on other busy cycles carry random inputs, and the request stream must continue unchanged.

// File: rtl/fetch_plan_pkg.sv
// Shared types for the reference fetch planner.
// Assumes the macroblock is 16x16 luma samples and holds at most 16 vectors.
package fetch_plan_pkg;
    localparam int NUM_MV  = 16;
    localparam int GEOM_W  = 5;

    typedef enum logic [2:0] {
        SHAPE_16X16 = 3'd0,
        SHAPE_16X8  = 3'd1,
        SHAPE_8X16  = 3'd2,
        SHAPE_8X8   = 3'd3,
        SHAPE_8X4   = 3'd4,
        SHAPE_4X8   = 3'd5,
        SHAPE_4X4   = 3'd6,
        SHAPE_RSVD  = 3'd7
    } shape_e;

    typedef struct packed {
        logic [GEOM_W-1:0] off_x;
        logic [GEOM_W-1:0] off_y;
        logic [GEOM_W-1:0] w;
        logic [GEOM_W-1:0] h;
    } part_geom_t;
endpackage

// File: rtl/part_geometry.sv
// Maps a shape code and partition index to offset and size inside the
// macroblock, plus the partition count. Purely combinational.
// Assumes idx stays below the count; code 7 is treated as 16x16.
module part_geometry
    import fetch_plan_pkg::*;
(
    input  shape_e     shape,
    input  logic [3:0] idx,
    output part_geom_t geom,
    output logic [4:0] n_parts
);
    // Decode offsets (z order for quadrants, x before y inside them).
    always_comb begin
        geom    = '0;
        n_parts = 5'd1;
        case (shape)
            SHAPE_16X8: begin
                geom.off_y = {1'b0, idx[0], 3'b000};
                geom.w = 5'd16; geom.h = 5'd8; n_parts = 5'd2;
            end
            SHAPE_8X16: begin
                geom.off_x = {1'b0, idx[0], 3'b000};
                geom.w = 5'd8; geom.h = 5'd16; n_parts = 5'd2;
            end
            SHAPE_8X8: begin
                geom.off_x = {1'b0, idx[0], 3'b000};
                geom.off_y = {1'b0, idx[1], 3'b000};
                geom.w = 5'd8; geom.h = 5'd8; n_parts = 5'd4;
            end
            SHAPE_8X4: begin
                geom.off_x = {1'b0, idx[1], 3'b000};
                geom.off_y = {1'b0, idx[2], idx[0], 2'b00};
                geom.w = 5'd8; geom.h = 5'd4; n_parts = 5'd8;
            end
            SHAPE_4X8: begin
                geom.off_x = {1'b0, idx[1], idx[0], 2'b00};
                geom.off_y = {1'b0, idx[2], 3'b000};
                geom.w = 5'd4; geom.h = 5'd8; n_parts = 5'd8;
            end
            SHAPE_4X4: begin
                geom.off_x = {1'b0, idx[2], idx[0], 2'b00};
                geom.off_y = {1'b0, idx[3], idx[1], 2'b00};
                geom.w = 5'd4; geom.h = 5'd4; n_parts = 5'd16;
            end
            default: begin
                geom.w = 5'd16; geom.h = 5'd16; n_parts = 5'd1;
            end
        endcase
    end
endmodule

// File: rtl/axis_window.sv
// One axis of a fetch window: start coordinate and length from the
// macroblock base, partition offset/size and one quarter-sample vector
// component. Assumes COORD_W > MV_W so the integer part sign-extends.
module axis_window #(
    parameter int MV_W    = 12,
    parameter int COORD_W = 14
) (
    input  logic [COORD_W-1:0] base,
    input  logic [4:0]         off,
    input  logic [4:0]         size,
    input  logic [MV_W-1:0]    mv,
    output logic [COORD_W-1:0] start,
    output logic [4:0]         len
);
    localparam int EXT_W = COORD_W - MV_W + 2;

    logic               frac;
    logic [COORD_W-1:0] mv_int;

    // Integer part of the vector and the interpolation margin.
    always_comb begin
        frac   = |mv[1:0];
        mv_int = {{EXT_W{mv[MV_W-1]}}, mv[MV_W-1:2]};
        start  = base + {{(COORD_W-5){1'b0}}, off} + mv_int
                 - (frac ? COORD_W'(2) : COORD_W'(0));
        len    = size + (frac ? 5'd5 : 5'd0);
    end
endmodule

// File: rtl/ref_fetch_planner.sv
// Walks the partitions of one macroblock and issues one reference window
// request per partition on a valid/ready stream, then reports the pixel
// total. Assumes inputs are stable only in the cycle mb_start is high.
module ref_fetch_planner
    import fetch_plan_pkg::*;
#(
    parameter int MB_IDX_W = 7,
    parameter int MV_W     = 12,
    parameter int COORD_W  = 14,
    parameter int PIX_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mb_start,
    input  logic [MB_IDX_W-1:0]        mb_col,
    input  logic [MB_IDX_W-1:0]        mb_row,
    input  logic [2:0]                 part_mode,
    input  logic [NUM_MV*2*MV_W-1:0]   mv_bus,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [COORD_W-1:0]         req_x,
    output logic [COORD_W-1:0]         req_y,
    output logic [4:0]                 req_w,
    output logic [4:0]                 req_h,
    output logic                       req_last,
    output logic                       mb_done,
    output logic [PIX_W-1:0]           mb_pixels
);
    localparam int SLOT_W = 2 * MV_W;
    localparam int PAD_W  = COORD_W - MB_IDX_W - 4;

    logic                busy_q;
    shape_e              shape_q;
    logic [MB_IDX_W-1:0] col_q, row_q;
    logic [SLOT_W-1:0]   mv_q [NUM_MV];
    logic [3:0]          idx_q;
    logic [PIX_W-1:0]    acc_q, pix_q;
    logic                done_q;

    part_geom_t          geom;
    logic [4:0]          n_parts;
    logic                fire, is_last, accept;
    logic [9:0]          area;

    logic [COORD_W-1:0]  ax_base  [2];
    logic [4:0]          ax_off   [2];
    logic [4:0]          ax_size  [2];
    logic [MV_W-1:0]     ax_mv    [2];
    logic [COORD_W-1:0]  ax_start [2];
    logic [4:0]          ax_len   [2];

    part_geometry u_geom (
        .shape   (shape_q),
        .idx     (idx_q),
        .geom    (geom),
        .n_parts (n_parts)
    );

    // Route per-axis inputs to the two window calculators.
    always_comb begin
        ax_base[0] = {{PAD_W{1'b0}}, col_q, 4'b0000};
        ax_base[1] = {{PAD_W{1'b0}}, row_q, 4'b0000};
        ax_off[0]  = geom.off_x;
        ax_off[1]  = geom.off_y;
        ax_size[0] = geom.w;
        ax_size[1] = geom.h;
        ax_mv[0]   = mv_q[idx_q][MV_W-1:0];
        ax_mv[1]   = mv_q[idx_q][SLOT_W-1:MV_W];
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        axis_window #(.MV_W(MV_W), .COORD_W(COORD_W)) u_axis (
            .base  (ax_base[a]),
            .off   (ax_off[a]),
            .size  (ax_size[a]),
            .mv    (ax_mv[a]),
            .start (ax_start[a]),
            .len   (ax_len[a])
        );
    end

    // Handshake and sequencing conditions.
    always_comb begin
        req_valid = busy_q;
        is_last   = ({1'b0, idx_q} == (n_parts - 5'd1));
        req_last  = busy_q & is_last;
        fire      = busy_q & req_ready;
        accept    = mb_start & (~busy_q | (fire & is_last));
        req_x     = ax_start[0];
        req_y     = ax_start[1];
        req_w     = ax_len[0];
        req_h     = ax_len[1];
        area      = req_w * req_h;
        mb_done   = done_q;
        mb_pixels = pix_q;
    end

    // Capture vectors when a macroblock is accepted.
    for (genvar k = 0; k < NUM_MV; k++) begin : g_mv
        always_ff @(posedge clk) begin
            if (!rst_n)      mv_q[k] <= '0;
            else if (accept) mv_q[k] <= mv_bus[k*SLOT_W +: SLOT_W];
        end
    end

    // Sequencer state, pixel accumulation and done reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            shape_q <= SHAPE_16X16;
            col_q   <= '0;
            row_q   <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            pix_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fire & is_last;
            if (fire & is_last) begin
                pix_q <= acc_q + PIX_W'(area);
                acc_q <= '0;
            end else if (fire) begin
                acc_q <= acc_q + PIX_W'(area);
            end
            if (accept) begin
                busy_q  <= 1'b1;
                shape_q <= shape_e'(part_mode);
                col_q   <= mb_col;
                row_q   <= mb_row;
                idx_q   <= '0;
            end else if (fire & is_last) begin
                busy_q <= 1'b0;
            end else if (fire) begin
                idx_q <= idx_q + 4'd1;
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_x) &&
            $stable(req_y) && $stable(req_w) && $stable(req_h)));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> mb_done);

    assert_win_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_w inside {5'd4, 5'd8, 5'd16, 5'd9, 5'd13, 5'd21} &&
                       req_h inside {5'd4, 5'd8, 5'd16, 5'd9, 5'd13, 5'd21}));

    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && mb_start) |=> req_valid);

    assert_pix_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mb_done |-> (mb_pixels >= PIX_W'(256) && mb_pixels <= PIX_W'(1296)));

    assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_last |-> req_valid);
endmodule

// File: tb/tb_ref_fetch_planner.sv
`timescale 1ns/1ps
module tb_ref_fetch_planner;
    localparam int MBW = 7, MVW = 12, CW = 14, PW = 16, NMV = 16;

    logic clk = 1'b0, rst_n = 1'b0, mb_start = 1'b0, req_ready = 1'b0;
    logic [MBW-1:0] mb_col = '0, mb_row = '0;
    logic [2:0] part_mode = '0;
    logic [NMV*2*MVW-1:0] mv_bus = '0;
    logic req_valid, req_last, mb_done;
    logic [CW-1:0] req_x, req_y;
    logic [4:0] req_w, req_h;
    logic [PW-1:0] mb_pixels;

    ref_fetch_planner #(.MB_IDX_W(MBW), .MV_W(MVW), .COORD_W(CW), .PIX_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .mb_col(mb_col),
        .mb_row(mb_row), .part_mode(part_mode), .mv_bus(mv_bus),
        .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x),
        .req_y(req_y), .req_w(req_w), .req_h(req_h), .req_last(req_last),
        .mb_done(mb_done), .mb_pixels(mb_pixels));

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;
    int cur_mode, cur_col, cur_row, cur_mx[NMV], cur_my[NMV];
    int nxt_mode, nxt_col, nxt_row, nxt_mx[NMV], nxt_my[NMV];
    int nparts[7] = '{1, 2, 2, 4, 8, 8, 16};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected partition geometry per R3.
    task automatic geom(input int mode, input int p, output int ox, output int oy,
                        output int w, output int h);
        int q, s;
        ox = 0; oy = 0; w = 16; h = 16;
        case (mode)
            1: begin oy = (p & 1) * 8; h = 8; end
            2: begin ox = (p & 1) * 8; w = 8; end
            3: begin ox = (p & 1) * 8; oy = (p >> 1) * 8; w = 8; h = 8; end
            4: begin q = p >> 1; s = p & 1; ox = (q & 1) * 8; oy = (q >> 1) * 8 + s * 4; w = 8; h = 4; end
            5: begin q = p >> 1; s = p & 1; ox = (q & 1) * 8 + s * 4; oy = (q >> 1) * 8; w = 4; h = 8; end
            6: begin q = p >> 2; s = p & 3; ox = (q & 1) * 8 + (s & 1) * 4;
                     oy = (q >> 1) * 8 + (s >> 1) * 4; w = 4; h = 4; end
            default: ;
        endcase
    endtask

    // Expected window for one axis per R4/R5.
    function automatic void axis(input int base, input int o, input int sz, input int mv,
                                 output int st, output int ln);
        bit fr = (mv & 3) != 0;
        st = base + o + (mv >>> 2) - (fr ? 2 : 0);
        ln = sz + (fr ? 5 : 0);
    endfunction

    task automatic put_nxt();
        part_mode = nxt_mode[2:0];
        mb_col = nxt_col[MBW-1:0];
        mb_row = nxt_row[MBW-1:0];
        for (int k = 0; k < NMV; k++) begin
            mv_bus[k*2*MVW +: MVW] = nxt_mx[k][MVW-1:0];
            mv_bus[k*2*MVW + MVW +: MVW] = nxt_my[k][MVW-1:0];
        end
    endtask

    task automatic put_junk();
        part_mode = 3'($urandom);
        mb_col = MBW'($urandom);
        mb_row = MBW'($urandom);
        for (int i = 0; i < NMV * 2; i++) mv_bus[i*MVW +: MVW] = MVW'($urandom);
    endtask

    task automatic cur_from_nxt();
        cur_mode = nxt_mode; cur_col = nxt_col; cur_row = nxt_row;
        for (int k = 0; k < NMV; k++) begin cur_mx[k] = nxt_mx[k]; cur_my[k] = nxt_my[k]; end
    endtask

    // kind: 0 random, 1 all integer, 2 all fractional, 3 x-only fractional
    task automatic gen_nxt(input int mode, input int kind);
        nxt_mode = mode;
        nxt_col = $urandom_range(120, 1);
        nxt_row = $urandom_range(60, 1);
        for (int k = 0; k < NMV; k++) begin
            int a = int'($urandom_range(400)) - 200;
            int b = int'($urandom_range(400)) - 200;
            case (kind)
                1: begin a = a & ~3; b = b & ~3; end
                2: begin a = a | 1; b = b | 3; end
                3: begin a = a | 2; b = b & ~3; end
                default: ;
            endcase
            nxt_mx[k] = a; nxt_my[k] = b;
        end
    endtask

    // At a negedge where the first request of cur should be visible.
    task automatic process_mb(input bit chain, input int exp_total);
        int p = 0, sum = 0, n = nparts[cur_mode];
        bit fin = 0;
        while (!fin) begin
            int ox, oy, w, h, ex, ey, ew, eh;
            bit rdy, lastp;
            mb_start = 1'b0;
            geom(cur_mode, p, ox, oy, w, h);
            axis(cur_col * 16, ox, w, cur_mx[p], ex, ew);
            axis(cur_row * 16, oy, h, cur_my[p], ey, eh);
            lastp = (p == n - 1);
            chk(req_valid == 1'b1, "R2 req_valid", int'(req_valid), 1);
            chk(int'($signed(req_x)) == ex, "R4/R6/R7 req_x", int'($signed(req_x)), ex);
            chk(req_w == 5'(ew), "R4/R3 req_w", int'(req_w), ew);
            chk(int'($signed(req_y)) == ey, "R5/R6/R7 req_y", int'($signed(req_y)), ey);
            chk(req_h == 5'(eh), "R5/R3 req_h", int'(req_h), eh);
            chk(req_last == lastp, "R2 req_last", int'(req_last), int'(lastp));
            rdy = ($urandom_range(2) != 0);
            if (lastp && chain) rdy = 1'b1;
            req_ready = rdy;
            if (lastp && rdy && chain) begin put_nxt(); mb_start = 1'b1; end
            else if (!(lastp && rdy) && $urandom_range(3) == 0) begin put_junk(); mb_start = 1'b1; end
            if (rdy) begin sum += ew * eh; if (lastp) fin = 1; p++; end
            @(posedge clk); @(negedge clk);
        end
        req_ready = 1'b0; mb_start = 1'b0;
        if (exp_total >= 0) chk(sum == exp_total, "R3 directed total", sum, exp_total);
        chk(mb_done == 1'b1, "R8 mb_done", int'(mb_done), 1);
        chk(int'(mb_pixels) == sum, "R8 mb_pixels", int'(mb_pixels), sum);
        if (!chain) begin
            chk(req_valid == 1'b0, "R9 idle after last", int'(req_valid), 0);
            @(negedge clk);
            chk(mb_done == 1'b0, "R8 done pulse", int'(mb_done), 0);
            chk(int'(mb_pixels) == sum, "R8 mb_pixels hold", int'(mb_pixels), sum);
        end
    endtask

    task automatic start_nxt();
        put_nxt(); mb_start = 1'b1;
        @(posedge clk); @(negedge clk);
        mb_start = 1'b0;
        cur_from_nxt();
    endtask

    task automatic run_mb(input int mode, input int kind, input int exp_total);
        gen_nxt(mode, kind);
        start_nxt();
        process_mb(1'b0, exp_total);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
        chk(req_last == 1'b0, "R1 req_last", int'(req_last), 0);
        chk(mb_done == 1'b0, "R1 mb_done", int'(mb_done), 0);
        chk(mb_pixels == '0, "R1 mb_pixels", int'(mb_pixels), 0);

        run_mb(0, 1, 256);    // R4 R5 integer vectors: footprint only
        run_mb(0, 2, 441);    // R4 R5 both fractional: 21x21
        run_mb(5, 3, 8 * 72); // R4 horizontal-only margin: 9x8
        run_mb(5, 2, 8 * 117);// R3 example window 9x13
        run_mb(6, 2, 1296);   // R3 sixteen 9x9 windows
        run_mb(2, 1, 256);    // R3 8x16 order

        // Random shapes, half of them chained into the final handshake (R9).
        gen_nxt($urandom_range(6), 0);
        start_nxt();
        for (int m = 0; m < 40; m++) begin
            bit ch = (m < 39) && ($urandom_range(1) == 1);
            if (ch) gen_nxt($urandom_range(6), $urandom_range(3));
            process_mb(ch, -1);
            if (ch) cur_from_nxt();
            else if (m < 39) begin gen_nxt($urandom_range(6), 0); start_nxt(); end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule